// File: doc/BRIEF.md
# Key-Locked Watchdog Timer with Early-Warning Threshold

This peripheral supervises software through a 32-bit down-counter that advances once per pulse of a 32.768 kHz tick strobe, giving 32768 steps per second. Software programs an expiry count and a separate early-warning threshold, each as a pair of 16-bit halves. When the counter steps onto the threshold, an interrupt is raised so software can react before the counter expires. When the counter steps onto zero, a reset request is raised and held until software clears it.

Every configuration write is guarded by a key register. Software first writes the 16-bit key value 0xE551 to the key register. After that it can change settings. It then writes any other value to close the block again. A new expiry value is not copied into the counter at once. The copy takes several ticks, and a busy flag in the status register is set for that whole time. The current count can be read as two halves. Reading the upper half captures the lower half in a snapshot, so the two halves read back belong to the same count.

The bus is a simple single-cycle register port using byte offsets. Reads return data one clock after the request. The reset input is asserted asynchronously and released through a two-stage synchronizer.

Top module: `wdg_top`

## Requirements
- R1: After reset the block is locked, the control register reads 0, the raw status reads 0, the count reads 0, and both `irq` and `rst_req` are low.
- R2: Writing 0xE551 in bits [15:0] to the key register (offset 0x20) unlocks the block. Writing any other value locks it. A read of offset 0x20 returns 1 in bit 0 while the block is unlocked.
- R3: While the block is locked, writes to every offset other than 0x20 have no effect. This covers control, load, threshold and clear.
- R4: The control register (offset 0x08) holds four bits, all readable: bit 0 enables the interrupt, bit 1 enables counting, bit 2 is a stored version-select bit, and bit 3 enables the reset request.
- R5: The expiry value is written with its upper half at offset 0x04 and its lower half at offset 0x00. Writing offset 0x00 starts a transfer. Raw status bit 4 (busy) is set from the next cycle until the third tick after the write, and at that tick the counter takes the new value.
- R6: While counting is enabled and no transfer completes, each tick lowers the counter by exactly one. A borrow propagates across the two halves. The counter holds its value while counting is disabled, and it stays at zero once it reaches zero.
- R7: The early-warning threshold has its lower half at offset 0x2C and its upper half at offset 0x30. When a tick steps the counter onto the threshold while the interrupt is enabled, raw status bit 0 is set and `irq` rises.
- R8: When a tick steps the counter onto zero while the reset request is enabled, raw status bit 3 is set. `rst_req` is then held high until the flag is cleared.
- R9: Writing offset 0x0C with bit 0 set clears the interrupt flag. Writing it with bit 3 set clears the reset flag.
- R10: A read of offset 0x1C returns counter bits [31:16] and stores counter bits [15:0] in a snapshot. A later read of offset 0x18 returns that snapshot, even if the counter has moved since.
- R11: Offset 0x14 reads the enabled status: bit 0 is the interrupt flag AND interrupt enable, and bit 3 is the reset flag AND reset enable. `irq` and `rst_req` follow these two bits, while raw status keeps the flags.
- R12: Read data appears on `bus_rdata` in the cycle after `bus_rd` is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle strobe at 32.768 kHz, synchronous to clk |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after bus_rd |
| irq | output | 1 | Level early-warning interrupt |
| rst_req | output | 1 | Level reset request |

## Verification
Register writes take effect at the clock edge that samples them. A read issued in one cycle returns data after the next edge. A tick updates the counter and both flags at the edge that samples it. `irq` and `rst_req` are driven from those flags and the control register with no further register, so they change at that same edge. A transfer completes on the third tick after the load write.

The bench drives every stimulus on the falling clock edge and checks outputs on that edge. Each read pushes its expected value into a queue at the moment the request is made. A monitor waits one time unit after the sampling rising edge, then pops the queue and compares. The expected values come from hand-counted tick sequences, including a borrow across the halves, a threshold hit, and an expiry.

// File: rtl/wdg_pkg.sv
`timescale 1ns/1ps
package wdg_pkg;
  localparam int ADDR_W = 6;

  localparam logic [ADDR_W-1:0] OFS_LOAD_LO = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_LOAD_HI = 6'h04;
  localparam logic [ADDR_W-1:0] OFS_CTRL    = 6'h08;
  localparam logic [ADDR_W-1:0] OFS_CLEAR   = 6'h0C;
  localparam logic [ADDR_W-1:0] OFS_RAW     = 6'h10;
  localparam logic [ADDR_W-1:0] OFS_MASKED  = 6'h14;
  localparam logic [ADDR_W-1:0] OFS_CNT_LO  = 6'h18;
  localparam logic [ADDR_W-1:0] OFS_CNT_HI  = 6'h1C;
  localparam logic [ADDR_W-1:0] OFS_KEY     = 6'h20;
  localparam logic [ADDR_W-1:0] OFS_PRE_LO  = 6'h2C;
  localparam logic [ADDR_W-1:0] OFS_PRE_HI  = 6'h30;

  localparam int BIT_INT  = 0;
  localparam int BIT_RST  = 3;
  localparam int BIT_BUSY = 4;

  // control bits 3..0
  typedef struct packed {
    logic rst_en;
    logic ver_sel;
    logic cnt_en;
    logic int_en;
  } ctrl_t;
endpackage

// File: rtl/wdg_regs.sv
`timescale 1ns/1ps
module wdg_regs
  import wdg_pkg::*;
#(
  parameter int          DATA_W = 32,
  parameter int          HALF_W = 16,
  parameter logic [15:0] KEY    = 16'hE551,
  localparam int         CNT_W  = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              raw_int,
  input  logic              raw_rst,
  input  logic              busy,
  input  logic [CNT_W-1:0]  cnt,
  output ctrl_t             ctrl,
  output logic [CNT_W-1:0]  load_val,
  output logic [CNT_W-1:0]  pre_val,
  output logic              load_go,
  output logic              clr_int,
  output logic              clr_rst,
  output logic [DATA_W-1:0] rdata
);

  logic              unl_q, unl_d;
  ctrl_t             ctrl_q, ctrl_d;
  logic [HALF_W-1:0] ld_lo_q, ld_lo_d, ld_hi_q, ld_hi_d;
  logic [HALF_W-1:0] pr_lo_q, pr_lo_d, pr_hi_q, pr_hi_d;
  logic [HALF_W-1:0] snap_q, snap_d;
  logic [DATA_W-1:0] rdata_q, rdata_d, rd_mux;
  logic              wr_ok;

  assign wr_ok = wr_en && unl_q;

  always_comb begin
    unl_d   = unl_q;
    ctrl_d  = ctrl_q;
    ld_lo_d = ld_lo_q;
    ld_hi_d = ld_hi_q;
    pr_lo_d = pr_lo_q;
    pr_hi_d = pr_hi_q;
    load_go = 1'b0;
    clr_int = 1'b0;
    clr_rst = 1'b0;
    if (wr_en && addr == OFS_KEY) unl_d = (wdata[15:0] == KEY);
    if (wr_ok) begin
      case (addr)
        OFS_LOAD_LO: begin ld_lo_d = wdata[HALF_W-1:0]; load_go = 1'b1; end
        OFS_LOAD_HI: ld_hi_d = wdata[HALF_W-1:0];
        OFS_CTRL:    ctrl_d  = ctrl_t'(wdata[3:0]);
        OFS_CLEAR:   begin clr_int = wdata[BIT_INT]; clr_rst = wdata[BIT_RST]; end
        OFS_PRE_LO:  pr_lo_d = wdata[HALF_W-1:0];
        OFS_PRE_HI:  pr_hi_d = wdata[HALF_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_mux = '0;
    case (addr)
      OFS_LOAD_LO: rd_mux = DATA_W'(ld_lo_q);
      OFS_LOAD_HI: rd_mux = DATA_W'(ld_hi_q);
      OFS_CTRL:    rd_mux = DATA_W'(ctrl_q);
      OFS_RAW: begin
        rd_mux[BIT_INT]  = raw_int;
        rd_mux[BIT_RST]  = raw_rst;
        rd_mux[BIT_BUSY] = busy;
      end
      OFS_MASKED: begin
        rd_mux[BIT_INT] = raw_int && ctrl_q.int_en;
        rd_mux[BIT_RST] = raw_rst && ctrl_q.rst_en;
      end
      OFS_CNT_LO:  rd_mux = DATA_W'(snap_q);
      OFS_CNT_HI:  rd_mux = DATA_W'(cnt[CNT_W-1:HALF_W]);
      OFS_KEY:     rd_mux = DATA_W'(unl_q);
      OFS_PRE_LO:  rd_mux = DATA_W'(pr_lo_q);
      OFS_PRE_HI:  rd_mux = DATA_W'(pr_hi_q);
      default: ;
    endcase
  end

  always_comb begin
    rdata_d = rdata_q;
    snap_d  = snap_q;
    if (rd_en) begin
      rdata_d = rd_mux;
      if (addr == OFS_CNT_HI) snap_d = cnt[HALF_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unl_q   <= 1'b0;
      ctrl_q  <= '0;
      ld_lo_q <= '0;
      ld_hi_q <= '0;
      pr_lo_q <= '0;
      pr_hi_q <= '0;
      snap_q  <= '0;
      rdata_q <= '0;
    end else begin
      unl_q   <= unl_d;
      ctrl_q  <= ctrl_d;
      ld_lo_q <= ld_lo_d;
      ld_hi_q <= ld_hi_d;
      pr_lo_q <= pr_lo_d;
      pr_hi_q <= pr_hi_d;
      snap_q  <= snap_d;
      rdata_q <= rdata_d;
    end
  end

  assign ctrl     = ctrl_q;
  assign load_val = {ld_hi_q, ld_lo_q};
  assign pre_val  = {pr_hi_q, pr_lo_q};
  assign rdata    = rdata_q;

  // R3: a locked block keeps its control setting
  p_locked_ctrl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !unl_q |=> $stable(ctrl_q));

  // R2: the key opens the block
  p_key_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_KEY && wdata[15:0] == KEY) |=> unl_q);

  // R10: upper-half read captures the lower half
  p_snap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == OFS_CNT_HI) |=> snap_q == $past(cnt[HALF_W-1:0]));
endmodule

// File: rtl/wdg_core.sv
`timescale 1ns/1ps
module wdg_core
  import wdg_pkg::*;
#(
  parameter int CNT_W      = 32,
  parameter int LOAD_TICKS = 3,
  localparam int LW        = $clog2(LOAD_TICKS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  ctrl_t            ctrl,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] pre_val,
  input  logic             load_go,
  input  logic             clr_int,
  input  logic             clr_rst,
  output logic [CNT_W-1:0] cnt,
  output logic             raw_int,
  output logic             raw_rst,
  output logic             busy
);

  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_dec;
  logic [LW-1:0]    left_q, left_d;
  logic             busy_q, busy_d, int_q, int_d, rst_q, rst_d;
  logic             load_done, step;

  assign cnt_dec   = cnt_q - CNT_W'(1);
  assign load_done = busy_q && tick && (left_q == LW'(1)) && !load_go;
  assign step      = ctrl.cnt_en && tick && (cnt_q != '0) && !load_done;

  always_comb begin
    busy_d = busy_q;
    left_d = left_q;
    if (load_go) begin
      busy_d = 1'b1;
      left_d = LW'(LOAD_TICKS);
    end else if (busy_q && tick) begin
      left_d = left_q - LW'(1);
      if (left_q == LW'(1)) busy_d = 1'b0;
    end
  end

  always_comb begin
    cnt_d = cnt_q;
    if (load_done)  cnt_d = load_val;
    else if (step)  cnt_d = cnt_dec;
  end

  always_comb begin
    int_d = int_q;
    rst_d = rst_q;
    if (clr_int) int_d = 1'b0;
    if (clr_rst) rst_d = 1'b0;
    if (step && ctrl.int_en && cnt_dec == pre_val) int_d = 1'b1;
    if (step && ctrl.rst_en && cnt_dec == '0)      rst_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      left_q <= '0;
      busy_q <= 1'b0;
      int_q  <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      left_q <= left_d;
      busy_q <= busy_d;
      int_q  <= int_d;
      rst_q  <= rst_d;
    end
  end

  assign cnt     = cnt_q;
  assign busy    = busy_q;
  assign raw_int = int_q;
  assign raw_rst = rst_q;

  // R5: end of transfer leaves the programmed value in the counter
  p_load_xfer_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> cnt_q == $past(load_val));

  // R6: one step per tick
  p_step_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.cnt_en && tick && !busy_q && cnt_q != '0) |=> cnt_q == $past(cnt_q) - CNT_W'(1));

  // R6: zero is a floor
  p_zero_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && !busy_q) |=> cnt_q == '0);

  // R7: interrupt flag rises only on the threshold
  p_pre_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_q) |-> cnt_q == $past(pre_val));

  // R8: reset flag holds until cleared
  p_rst_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_q && !clr_rst) |=> rst_q);
endmodule

// File: rtl/wdg_top.sv
`timescale 1ns/1ps
module wdg_top
  import wdg_pkg::*;
#(
  parameter int          DATA_W     = 32,
  parameter int          HALF_W     = 16,
  parameter int          LOAD_TICKS = 3,
  parameter logic [15:0] KEY        = 16'hE551,
  localparam int         CNT_W      = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  output logic              rst_req
);

  logic [1:0]       rsync_q;
  logic             srst_n;
  ctrl_t            ctrl;
  logic [CNT_W-1:0] load_val, pre_val, cnt;
  logic             load_go, clr_int, clr_rst, raw_int, raw_rst, busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign srst_n = rsync_q[1];

  wdg_regs #(.DATA_W(DATA_W), .HALF_W(HALF_W), .KEY(KEY)) u_regs (
    .clk(clk), .rst_n(srst_n), .wr_en(bus_wr), .rd_en(bus_rd),
    .addr(bus_addr), .wdata(bus_wdata), .raw_int(raw_int), .raw_rst(raw_rst),
    .busy(busy), .cnt(cnt), .ctrl(ctrl), .load_val(load_val), .pre_val(pre_val),
    .load_go(load_go), .clr_int(clr_int), .clr_rst(clr_rst), .rdata(bus_rdata)
  );

  wdg_core #(.CNT_W(CNT_W), .LOAD_TICKS(LOAD_TICKS)) u_core (
    .clk(clk), .rst_n(srst_n), .tick(tick), .ctrl(ctrl), .load_val(load_val),
    .pre_val(pre_val), .load_go(load_go), .clr_int(clr_int), .clr_rst(clr_rst),
    .cnt(cnt), .raw_int(raw_int), .raw_rst(raw_rst), .busy(busy)
  );

  assign irq     = raw_int && ctrl.int_en;
  assign rst_req = raw_rst && ctrl.rst_en;
endmodule

// File: tb/wdg_top_test.sv
`timescale 1ns/1ps
module wdg_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, rst_req;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    logic [31:0] exp;
    string       req;
  } item_t;
  item_t sb_q[$];

  always #2 clk = ~clk;

  wdg_top uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .rst_req(rst_req)
  );

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [31:0] e, input string req);
    item_t it;
    @(negedge clk);
    it.exp = e; it.req = req;
    sb_q.push_back(it);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic do_tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic chk(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b", req, act, exp);
    end
  endtask

  // monitor: compare read data one edge after the request
  always @(posedge clk) begin
    if (bus_rd) begin
      item_t it;
      #1;
      checks++;
      if (sb_q.size() == 0) begin
        fails++;
        $display("FAIL R12: unexpected read data got %h expected none", bus_rdata);
      end else begin
        it = sb_q.pop_front();
        if (bus_rdata !== it.exp) begin
          fails++;
          $display("FAIL %s: got %h expected %h", it.req, bus_rdata, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk(irq, 1'b0, "R1 irq");
    chk(rst_req, 1'b0, "R1 rst_req");
    rd(6'h20, 32'h0, "R1 key state");
    rd(6'h08, 32'h0, "R1 control");
    rd(6'h10, 32'h0, "R1 raw status");
    rd(6'h1C, 32'h0, "R1 count high");

    // R3 writes ignored while locked
    wr(6'h08, 32'hF);
    rd(6'h08, 32'h0, "R3 control locked");
    wr(6'h00, 32'h5);
    rd(6'h10, 32'h0, "R3 load locked no busy");

    // R2 key
    wr(6'h20, 32'hE551);
    rd(6'h20, 32'h1, "R2 unlocked");
    wr(6'h20, 32'h1234);
    rd(6'h20, 32'h0, "R2 relocked");
    wr(6'h20, 32'hE551);

    // R4 control bits
    wr(6'h08, 32'h4);
    rd(6'h08, 32'h4, "R4 version bit");

    // R5 load transfer
    wr(6'h04, 32'h0001);
    wr(6'h00, 32'h0010);
    rd(6'h10, 32'h10, "R5 busy after write");
    do_tick(2);
    rd(6'h10, 32'h10, "R5 busy after two ticks");
    do_tick(1);
    rd(6'h10, 32'h0, "R5 busy cleared");
    rd(6'h1C, 32'h1, "R5 count high");
    rd(6'h18, 32'h10, "R5 count low");

    // R6 decrement and hold
    wr(6'h08, 32'h6);
    do_tick(3);
    rd(6'h1C, 32'h1, "R6 high after steps");
    rd(6'h18, 32'hD, "R6 low after steps");
    wr(6'h08, 32'h4);
    do_tick(1);
    rd(6'h1C, 32'h1, "R6 hold high");
    rd(6'h18, 32'hD, "R6 hold low");

    // R10 snapshot coherence
    wr(6'h08, 32'h6);
    rd(6'h1C, 32'h1, "R10 high");
    do_tick(1);
    rd(6'h18, 32'hD, "R10 low from snapshot");
    rd(6'h1C, 32'h1, "R10 high again");
    rd(6'h18, 32'hC, "R10 low fresh");

    // R6 borrow across halves
    wr(6'h08, 32'h4);
    wr(6'h04, 32'h0001);
    wr(6'h00, 32'h0000);
    do_tick(3);
    wr(6'h08, 32'h6);
    do_tick(1);
    rd(6'h1C, 32'h0, "R6 borrow high");
    rd(6'h18, 32'hFFFF, "R6 borrow low");

    // R7 threshold, R11 masking, R9 clear
    wr(6'h08, 32'h4);
    wr(6'h30, 32'h0);
    wr(6'h2C, 32'h3);
    wr(6'h04, 32'h0);
    wr(6'h00, 32'h5);
    do_tick(3);
    wr(6'h08, 32'hF);
    do_tick(1);
    chk(irq, 1'b0, "R7 irq before threshold");
    do_tick(1);
    chk(irq, 1'b1, "R7 irq at threshold");
    rd(6'h10, 32'h1, "R7 raw int");
    rd(6'h14, 32'h1, "R11 masked int");
    wr(6'h08, 32'hE);
    chk(irq, 1'b0, "R11 irq masked");
    rd(6'h10, 32'h1, "R11 raw kept");
    rd(6'h14, 32'h0, "R11 masked off");
    wr(6'h08, 32'hF);
    chk(irq, 1'b1, "R11 irq unmasked");
    wr(6'h0C, 32'h1);
    chk(irq, 1'b0, "R9 int cleared");
    rd(6'h10, 32'h0, "R9 raw int cleared");

    // R8 expiry
    do_tick(2);
    chk(rst_req, 1'b0, "R8 no request before zero");
    do_tick(1);
    chk(rst_req, 1'b1, "R8 request at zero");
    rd(6'h10, 32'h8, "R8 raw reset");
    rd(6'h14, 32'h8, "R11 masked reset");
    do_tick(2);
    rd(6'h1C, 32'h0, "R6 floor high");
    rd(6'h18, 32'h0, "R6 floor low");
    chk(rst_req, 1'b1, "R8 request held");

    // R3 clear ignored while locked, then R9
    wr(6'h20, 32'h0);
    wr(6'h0C, 32'h8);
    chk(rst_req, 1'b1, "R3 locked clear ignored");
    rd(6'h10, 32'h8, "R3 raw reset kept");
    wr(6'h20, 32'hE551);
    wr(6'h0C, 32'h8);
    chk(rst_req, 1'b0, "R9 reset cleared");
    rd(6'h10, 32'h0, "R9 raw reset cleared");

    repeat (3) @(negedge clk);
    if (sb_q.size() != 0) begin
      checks++; fails++;
      $display("FAIL R12: got %0d pending reads expected 0", sb_q.size());
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule